// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a register-mapped watchdog. A 32-bit up-counter is advanced by a slow tick, with an optional divide-by-power-of-two prescaler in front of it. Software can only start or stop the counter by writing two specific key words, one after the other, to a key register. It keeps the system alive by writing a new value to a trigger register, which reloads the counter from a load register. If the counter runs past its all-ones value, the block raises a reset request for a fixed number of bus clocks and starts again from the load value.

Bus writes are posted. Each write lands in a staging register and sets a pending flag. The staged value takes effect on the next slow tick, and that tick clears the flag. The slow tick is a one-cycle enable pulse in the bus clock domain. It marks each edge of the 32 kHz time base. Reads are combinational and return the values in effect, not the staged ones.

Register offsets are byte addresses:
- 0x00 revision (read only)
- 0x04 control
- 0x08 counter (read only)
- 0x0C load
- 0x10 trigger
- 0x14 key
- 0x18 pending status (read only)

Top module: `keyed_wdt`

## Requirements
- R1: After reset the counter is stopped. The counter, control, load and pending status all read 0, and `reset_req` is low.
- R2: Offset 0x00 returns the parameter `REVISION` in bits 7:0. Bits 31:8 read as zero.
- R3: A write to a posted register sets its flag in the status register at 0x18. The flags are control in bit 0, load in bit 2, trigger in bit 3 and key in bit 4. The next slow tick applies the staged value and clears the flag.
- R4: The key words 0x0000BBBB and then 0x00004444, applied as consecutive key writes, start the counter. While it runs with the prescaler off, the counter rises by one on every slow tick.
- R5: The key words 0x0000AAAA and then 0x00005555, applied as consecutive key writes, stop the counter. The tick that applies the stop still counts. After that the counter holds its value.
- R6: If the key write after a first key word is not the matching second word, the sequence is dropped. The counter state is unchanged, and the block waits for a new first word.
- R7: An applied trigger value that differs from the last applied trigger value loads the counter from the load register. An equal value causes no reload. The last trigger value is 0 after reset.
- R8: In the control register, bit 5 enables the prescaler and bits 4:2 hold its exponent N. With the prescaler enabled, the counter advances once every 2^N slow ticks.
- R9: While the counter runs, staged control and load values are discarded when applied. The control and load registers read back unchanged.
- R10: When a running counter advances from 0xFFFFFFFF, it is reloaded from the load register. `reset_req` is then high for exactly `RST_CYCLES` bus clocks.
- R11: Offset 0x08 returns the live counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle pulse per slow time-base edge |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| reset_req | output | 1 | Reset request pulse on overflow |

## Verification
The counter is tried with four patterns:
- Plain single-tick counting, which separates correct arming from a counter that runs on its own.
- A repeated trigger value followed by a fresh one, which separates value-change reload from reload on every write.
- A prescaled run sampled just before and just after the 2^N boundary, which exposes off-by-one dividers.
- A start from just below all-ones, which shows the wrap reload and the exact pulse length.

Broken key sequences and configuration writes made while the counter runs are checked through readback. This shows that they change nothing.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int          AW         = 5,
  parameter int          DW         = 32,
  parameter int          RST_CYCLES = 4,
  parameter logic [7:0]  REVISION   = 8'h31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_tick,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          reset_req
);
  localparam int RCW = $clog2(RST_CYCLES + 1);
  localparam logic [2:0] A_REV = 3'd0, A_CTRL = 3'd1, A_CNT = 3'd2, A_LOAD = 3'd3,
                         A_TRIG = 3'd4, A_KEY = 3'd5, A_STAT = 3'd6;
  localparam logic [31:0] ARM_A = 32'h0000_BBBB, ARM_B = 32'h0000_4444,
                          DIS_A = 32'h0000_AAAA, DIS_B = 32'h0000_5555;

  typedef enum logic [1:0] {K_IDLE, K_ARM, K_DIS} key_t;

  logic [31:0]   ctrl_stg, load_stg, trig_stg, key_stg;
  logic [4:0]    pend;
  logic          ps_en, running;
  logic [2:0]    ptv;
  logic [DW-1:0] load_q, counter, load_nx;
  logic [31:0]   last_trig;
  logic [6:0]    psc;
  logic [RCW-1:0] rst_cnt;
  key_t          kst;

  wire [2:0] sel  = bus_addr[4:2];
  wire       wr_en = bus_sel & bus_wr;
  wire [6:0] mask = (7'd1 << ptv) - 7'd1;
  wire       advance = running && (!ps_en || psc == mask);
  wire       reload  = pend[3] && (trig_stg != last_trig);

  assign load_nx   = (pend[2] && !running) ? load_stg[DW-1:0] : load_q;
  assign reset_req = (rst_cnt != '0);

  always_comb begin
    case (sel)
      A_REV:   bus_rdata = {24'd0, REVISION};
      A_CTRL:  bus_rdata = {26'd0, ps_en, ptv, 2'b00};
      A_CNT:   bus_rdata = 32'(counter);
      A_LOAD:  bus_rdata = 32'(load_q);
      A_TRIG:  bus_rdata = last_trig;
      A_STAT:  bus_rdata = {27'd0, pend};
      default: bus_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_stg <= '0; load_stg <= '0; trig_stg <= '0; key_stg <= '0;
      pend <= '0; ps_en <= 1'b0; ptv <= '0; running <= 1'b0;
      load_q <= '0; counter <= '0; last_trig <= '0; psc <= '0;
      rst_cnt <= '0; kst <= K_IDLE;
    end else begin
      if (rst_cnt != '0) rst_cnt <= rst_cnt - 1'b1;
      if (slow_tick) begin
        pend <= '0;
        if (pend[0] && !running) begin
          ps_en <= ctrl_stg[5];
          ptv   <= ctrl_stg[4:2];
        end
        load_q <= load_nx;
        if (pend[3]) last_trig <= trig_stg;
        if (reload) begin
          counter <= load_nx;
          psc     <= '0;
        end else if (running) begin
          if (advance) begin
            psc <= '0;
            if (counter == '1) begin
              counter <= load_nx;
              rst_cnt <= RCW'(RST_CYCLES);
            end else begin
              counter <= counter + 1'b1;
            end
          end else begin
            psc <= psc + 1'b1;
          end
        end else begin
          psc <= '0;
        end
        if (pend[4]) begin
          case (kst)
            K_IDLE:  kst <= (key_stg == ARM_A) ? K_ARM : (key_stg == DIS_A) ? K_DIS : K_IDLE;
            K_ARM: begin
              if (key_stg == ARM_B) running <= 1'b1;
              kst <= K_IDLE;
            end
            K_DIS: begin
              if (key_stg == DIS_B) running <= 1'b0;
              kst <= K_IDLE;
            end
            default: kst <= K_IDLE;
          endcase
        end
      end
      if (wr_en) begin
        case (sel)
          A_CTRL: begin ctrl_stg <= bus_wdata; pend[0] <= 1'b1; end
          A_LOAD: begin load_stg <= bus_wdata; pend[2] <= 1'b1; end
          A_TRIG: begin trig_stg <= bus_wdata; pend[3] <= 1'b1; end
          A_KEY:  begin key_stg  <= bus_wdata; pend[4] <= 1'b1; end
          default: ;
        endcase
      end
    end
  end

  assert_pend_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_tick && !wr_en) |=> (pend == 5'd0));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_tick && running && !ps_en && !pend[3] && counter != '1) |=> (counter == $past(counter) + 1'b1));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !(slow_tick && pend[3])) |=> $stable(counter));

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> ($stable(load_q) && $stable(ps_en) && $stable(ptv)));

  assert_wrap_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> ($past(counter) == '1));
endmodule

// File: tb/keyed_wdt_test.sv
module keyed_wdt_test;
  logic clk = 0, rst_n = 0, slow_tick = 0, bus_sel = 0, bus_wr = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        reset_req;
  int checks = 0, fails = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  event mon_ev;

  keyed_wdt uut (.clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .reset_req(reset_req));

  always #2 clk = ~clk;

  always @(mon_ev) begin
    item_t it;
    it = q.pop_front();
    checks++;
    if (bus_rdata !== it.exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk); bus_addr = a;
    it.exp = e; it.tag = tag; q.push_back(it);
    #1 -> mon_ev;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_tick = 1;
      @(negedge clk); slow_tick = 0;
    end
  endtask

  task automatic key(input logic [31:0] k);
    wr(5'h14, k); tick(1);
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(5'h08, 32'h0, "R1 counter");
    rd(5'h04, 32'h0, "R1 control");
    rd(5'h0C, 32'h0, "R1 load");
    rd(5'h18, 32'h0, "R1 status");
    chk_bit(reset_req, 1'b0, "R1 reset_req");
    // R2 revision
    rd(5'h00, 32'h31, "R2 revision");
    // R3 posted load
    wr(5'h0C, 32'h100);
    rd(5'h18, 32'h04, "R3 load pending");
    tick(1);
    rd(5'h18, 32'h0, "R3 load cleared");
    rd(5'h0C, 32'h100, "R3 load applied");
    // R7 first trigger reloads
    wr(5'h10, 32'h1);
    rd(5'h18, 32'h08, "R3 trigger pending");
    tick(1);
    rd(5'h08, 32'h100, "R7 reload");
    // R4 arm
    wr(5'h14, ARM_A()); tick(1);
    wr(5'h14, 32'h4444);
    rd(5'h18, 32'h10, "R3 key pending");
    tick(1);
    tick(3);
    rd(5'h08, 32'h103, "R4 R11 counting");
    // R7 same value ignored, new value reloads
    wr(5'h10, 32'h1); tick(1);
    rd(5'h08, 32'h104, "R7 repeat ignored");
    wr(5'h10, 32'h2); tick(1);
    rd(5'h08, 32'h100, "R7 new value reload");
    // R9 config frozen while running
    wr(5'h0C, 32'h500); tick(1);
    rd(5'h0C, 32'h100, "R9 load ignored");
    rd(5'h08, 32'h101, "R9 counter");
    wr(5'h04, 32'h3C); tick(1);
    rd(5'h04, 32'h0, "R9 control ignored");
    // R5 disarm
    key(32'hAAAA); key(32'h5555);
    rd(5'h08, 32'h104, "R5 last count");
    tick(2);
    rd(5'h08, 32'h104, "R5 held");
    // R6 broken sequence
    key(32'hBBBB); key(32'h1234); key(32'h4444);
    tick(1);
    rd(5'h08, 32'h104, "R6 stays stopped");
    // R8 prescaler 2^2
    wr(5'h04, 32'h28); tick(1);
    rd(5'h04, 32'h28, "R8 control applied");
    key(32'hBBBB); key(32'h4444);
    tick(3);
    rd(5'h08, 32'h104, "R8 before boundary");
    tick(1);
    rd(5'h08, 32'h105, "R8 at boundary");
    // R10 overflow
    key(32'hAAAA); key(32'h5555);
    wr(5'h04, 32'h0); wr(5'h0C, 32'hFFFF_FFFE); wr(5'h10, 32'h4);
    tick(1);
    rd(5'h08, 32'hFFFF_FFFE, "R10 preload");
    key(32'hBBBB); key(32'h4444);
    tick(1);
    chk_bit(reset_req, 1'b0, "R10 no early pulse");
    rd(5'h08, 32'hFFFF_FFFF, "R10 all ones");
    tick(1);
    n = 0;
    while (reset_req === 1'b1 && n < 50) begin n++; @(negedge clk); end
    checks++;
    if (n != 4) begin fails++; $display("FAIL R10 pulse length: got %0d expected 4", n); end
    rd(5'h08, 32'hFFFF_FFFE, "R10 reloaded");
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic logic [31:0] ARM_A();
    return 32'hBBBB;
  endfunction
endmodule